// File: doc/BRIEF.md
# Self-Checking Systematic (15,7) LDPC Encoder

This block turns a 7-bit information word into a 15-bit codeword of a cyclic (15,7) low-density parity-check code with minimum distance 5. The code is used in systematic form. The information bits pass through unchanged into the low seven codeword bits. Eight parity bits are placed above them, and each parity bit is the XOR of a fixed subset of the information bits. Those subsets come from the generator polynomial g(x) = 1 + x^4 + x^6 + x^7 + x^8.

Every candidate codeword is checked by a syndrome checker inside the block before it is released. The checker applies fifteen weight-4 parity checks, which are the cyclic shifts of one row. A candidate that violates any check is thrown away, and the word is encoded again in the next cycle. A word that still fails after its last permitted retry puts the block into a fault state. That state holds until reset, and no further word is accepted or released.

A test port XORs an arbitrary pattern onto the parity bits of the candidate. This lets the retry path and the fault path be exercised deliberately. Words enter through a valid/ready handshake. The result is presented on registered outputs with a one-cycle valid strobe and the number of retries the word needed.

Top module: `ldpc_selfcheck_enc`

## Requirements
- R1: `in_ready` is high exactly when the block is idle and not faulted. A word is taken when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` then stays low from the next cycle until the cycle after the word is released.
- R2: In every released codeword, `out_code[6:0]` equals the information word that was taken, bit for bit.
- R3: Parity bit `out_code[7+k]` (k = 0..7) is the XOR of every information bit j whose remainder x^(8+j) mod g(x) has a 1 at coefficient k, with g(x) = 1 + x^4 + x^6 + x^7 + x^8. As a consequence, the cyclic word {out_code[6:0], out_code[14:7]} is a multiple of g(x). Information word 7'h01 gives codeword 15'h6881.
- R4: On each attempt, the candidate parity is the computed parity XOR `inj_flip` (bit k of `inj_flip` affects `out_code[7+k]`). An attempt made with any nonzero `inj_flip` fails the syndrome check and is not released.
- R5: After a word is taken at edge t, the first attempt is judged at edge t+1. Each failed attempt adds one cycle. The first passing attempt, at edge t+1+r, sets `out_valid` high for exactly one cycle and presents its codeword.
- R6: At release, `out_retry` equals the number r of failed attempts for that word, from 0 to 3. `out_retry` and `out_code` hold until the next release.
- R7: If the 4th attempt of a word fails (3 retries used up), `enc_fault` goes high and stays high until reset. The word is never released, and `in_ready` stays low.
- R8: Synchronous active-high reset sets `out_valid`=0, `in_ready`=1, `enc_fault`=0, `out_retry`=0 and `out_code`=0. It also clears a fault.
- R9: While the block is idle, `inj_flip` has no effect. No output changes unless a word is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Information word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_info | input | 7 | Information word |
| inj_flip | input | 8 | Test pattern XORed onto the candidate parity bits |
| out_valid | output | 1 | One-cycle strobe marking a released codeword |
| out_code | output | 15 | Released codeword: information in [6:0], parity in [14:7] |
| out_retry | output | 2 | Number of failed attempts for the released word |
| enc_fault | output | 1 | Sticky flag: a word failed every permitted attempt |

## Verification
The last permitted attempt and the fault decision fall on the same clock edge. On that edge the block either releases the word with a retry count of 3, or it gives up and raises the fault flag. The bench provokes both outcomes by holding the parity-flip pattern for exactly three attempt cycles on one word and for four on another. In the first case it expects a release whose retry count is 3 and no fault. In the second it expects no release, a raised flag and a dropped `in_ready`, all in the cycle its behavioural model predicts. A stream phase with `in_valid` held high and single-cycle flips at random moments also makes acceptance, retries and releases collide with the handshake edge. Those cycles are compared against the same model.

// File: rtl/ldpc_enc_pkg.sv
package ldpc_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ENC  = 2'd1,
    ST_DEAD = 2'd2
  } enc_state_e;

  // x^e reduced modulo a polynomial of degree deg (coefficients in gpoly)
  function automatic logic [63:0] xpow_mod(input int e, input logic [63:0] gpoly,
                                           input int deg);
    logic [63:0] r;
    logic [63:0] low_mask;
    logic        top;
    low_mask = (64'd1 << deg) - 64'd1;
    r = 64'd1;
    for (int i = 0; i < e; i++) begin
      top = r[deg-1];
      r = (r << 1) & low_mask;
      if (top) r = r ^ (gpoly & low_mask);
    end
    return r;
  endfunction

  // information bits feeding parity bit k
  function automatic logic [63:0] col_mask(input int k, input int ninfo, input int npar,
                                           input logic [63:0] gpoly);
    logic [63:0] m;
    logic [63:0] rem;
    m = 64'd0;
    for (int j = 0; j < ninfo; j++) begin
      rem = xpow_mod(npar + j, gpoly, npar);
      m[j] = rem[k];
    end
    return m;
  endfunction

  // row r of the circulant check matrix built from h(x)
  function automatic logic [63:0] row_mask(input int r, input int n,
                                           input logic [63:0] hpoly, input int hdeg);
    logic [63:0] m;
    m = 64'd0;
    for (int e = 0; e <= hdeg; e++) begin
      if (hpoly[e]) m[(r - e + n) % n] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ldpc_par_gen.sv
module ldpc_par_gen #(
  parameter int          INFO_W   = 7,
  parameter int          PAR_W    = 8,
  parameter logic [63:0] GEN_POLY = 64'h1D1
) (
  input  logic [INFO_W-1:0] info,
  output logic [PAR_W-1:0]  par
);

  for (genvar k = 0; k < PAR_W; k++) begin : g_par
    localparam logic [63:0] SEL = ldpc_enc_pkg::col_mask(k, INFO_W, PAR_W, GEN_POLY);
    assign par[k] = ^(info & SEL[INFO_W-1:0]);
  end

endmodule

// File: rtl/ldpc_syn_chk.sv
module ldpc_syn_chk #(
  parameter int          CODE_W   = 15,
  parameter logic [63:0] CHK_POLY = 64'hD1,
  parameter int          CHK_DEG  = 7
) (
  input  logic [CODE_W-1:0] word,
  output logic              err
);

  logic [CODE_W-1:0] syn;

  for (genvar r = 0; r < CODE_W; r++) begin : g_row
    localparam logic [63:0] ROW = ldpc_enc_pkg::row_mask(r, CODE_W, CHK_POLY, CHK_DEG);
    assign syn[r] = ^(word & ROW[CODE_W-1:0]);
  end

  assign err = |syn;

endmodule

// File: rtl/ldpc_enc_ctrl.sv
module ldpc_enc_ctrl #(
  parameter int INFO_W    = 7,
  parameter int CODE_W    = 15,
  parameter int MAX_RETRY = 3,
  parameter int RTY_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INFO_W-1:0] in_info,
  output logic              in_ready,
  output logic [INFO_W-1:0] info_q,
  input  logic [CODE_W-1:0] cand,
  input  logic              chk_err,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic [RTY_W-1:0]  out_retry,
  output logic              enc_fault
);
  import ldpc_enc_pkg::*;

  localparam logic [RTY_W-1:0] RTY_LAST = RTY_W'(MAX_RETRY);

  enc_state_e       state;
  logic [RTY_W-1:0] tries;

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      info_q    <= '0;
      tries     <= '0;
      out_valid <= 1'b0;
      out_code  <= '0;
      out_retry <= '0;
      enc_fault <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            info_q <= in_info;
            tries  <= '0;
            state  <= ST_ENC;
          end
        end
        ST_ENC: begin
          if (!chk_err) begin
            out_valid <= 1'b1;
            out_code  <= cand;
            out_retry <= tries;
            state     <= ST_IDLE;
          end else if (tries == RTY_LAST) begin
            enc_fault <= 1'b1;
            state     <= ST_DEAD;
          end else begin
            tries <= tries + 1'b1;
          end
        end
        default: state <= ST_DEAD;
      endcase
    end
  end

endmodule

// File: rtl/ldpc_selfcheck_enc.sv
module ldpc_selfcheck_enc #(
  parameter int          INFO_W    = 7,
  parameter int          CODE_W    = 15,
  parameter logic [63:0] GEN_POLY  = 64'h1D1,
  parameter logic [63:0] CHK_POLY  = 64'hD1,
  parameter int          CHK_DEG   = 7,
  parameter int          MAX_RETRY = 3,
  localparam int         PAR_W     = CODE_W - INFO_W,
  localparam int         RTY_W     = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INFO_W-1:0] in_info,
  input  logic [PAR_W-1:0]  inj_flip,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic [RTY_W-1:0]  out_retry,
  output logic              enc_fault
);

  logic [INFO_W-1:0] info_q;
  logic [PAR_W-1:0]  par_raw;
  logic [PAR_W-1:0]  par_cand;
  logic [CODE_W-1:0] cand;
  logic [CODE_W-1:0] cyc_word;
  logic              chk_err;

  ldpc_par_gen #(.INFO_W(INFO_W), .PAR_W(PAR_W), .GEN_POLY(GEN_POLY)) u_par (
    .info (info_q),
    .par  (par_raw)
  );

  assign par_cand = par_raw ^ inj_flip;
  assign cand     = {par_cand, info_q};
  // cyclic order: parity at low powers, information above
  assign cyc_word = {cand[INFO_W-1:0], cand[CODE_W-1:INFO_W]};

  ldpc_syn_chk #(.CODE_W(CODE_W), .CHK_POLY(CHK_POLY), .CHK_DEG(CHK_DEG)) u_syn (
    .word (cyc_word),
    .err  (chk_err)
  );

  ldpc_enc_ctrl #(.INFO_W(INFO_W), .CODE_W(CODE_W), .MAX_RETRY(MAX_RETRY),
                  .RTY_W(RTY_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_info   (in_info),
    .in_ready  (in_ready),
    .info_q    (info_q),
    .cand      (cand),
    .chk_err   (chk_err),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_retry (out_retry),
    .enc_fault (enc_fault)
  );

endmodule

// File: rtl/ldpc_selfcheck_enc_chk.sv
module ldpc_selfcheck_enc_chk #(
  parameter int          INFO_W    = 7,
  parameter int          CODE_W    = 15,
  parameter logic [63:0] GEN_POLY  = 64'h1D1,
  parameter int          PAR_W     = 8,
  parameter int          RTY_W     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [INFO_W-1:0] in_info,
  input logic [PAR_W-1:0]  inj_flip,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code,
  input logic [RTY_W-1:0]  out_retry,
  input logic              enc_fault
);

  logic [INFO_W-1:0] cap_info;
  logic              busy_q;
  logic [7:0]        fails_q;
  logic              cw_ok;

  function automatic logic divides(input logic [CODE_W-1:0] c);
    logic [63:0] w;
    w = 64'd0;
    w[CODE_W-1:0] = {c[INFO_W-1:0], c[CODE_W-1:INFO_W]};
    for (int d = CODE_W - 1; d >= PAR_W; d--) begin
      if (w[d]) w = w ^ (GEN_POLY << (d - PAR_W));
    end
    return (w == 64'd0);
  endfunction

  assign cw_ok = divides(out_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_info <= '0;
      busy_q   <= 1'b0;
      fails_q  <= '0;
    end else if (in_valid && in_ready) begin
      cap_info <= in_info;
      busy_q   <= 1'b1;
      fails_q  <= '0;
    end else if (out_valid || enc_fault) begin
      busy_q <= 1'b0;
    end else if (busy_q && (inj_flip != '0)) begin
      fails_q <= fails_q + 8'd1;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);                                   // R1
  AST_SYS_BITS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_code[INFO_W-1:0] == cap_info));                      // R2
  AST_CODEWORD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cw_ok);                                                   // R3
  AST_FLIP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (inj_flip != '0) && !out_valid && !enc_fault) |=> !out_valid); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);                                              // R5
  AST_RETRY_COUNT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (8'(out_retry) == fails_q));                              // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    enc_fault |=> enc_fault);                                               // R7
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    enc_fault |-> (!out_valid && !in_ready));                               // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !out_valid);                                // R9

endmodule

bind ldpc_selfcheck_enc ldpc_selfcheck_enc_chk #(
  .INFO_W(INFO_W), .CODE_W(CODE_W), .GEN_POLY(GEN_POLY), .PAR_W(PAR_W), .RTY_W(RTY_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_info   (in_info),
  .inj_flip  (inj_flip),
  .out_valid (out_valid),
  .out_code  (out_code),
  .out_retry (out_retry),
  .enc_fault (enc_fault)
);

// File: tb/sim_ldpc_selfcheck_enc.sv
module sim_ldpc_selfcheck_enc;

  localparam int MAX_RETRY = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  in_info = '0;
  logic [7:0]  inj_flip = '0;
  logic        in_ready, out_valid, enc_fault;
  logic [14:0] out_code;
  logic [1:0]  out_retry;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;   // 125 MHz

  ldpc_selfcheck_enc u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_info(in_info),
    .inj_flip(inj_flip), .out_valid(out_valid), .out_code(out_code),
    .out_retry(out_retry), .enc_fault(enc_fault)
  );

  // polynomial long division by g(x) = 1 + x^4 + x^6 + x^7 + x^8
  function automatic logic [14:0] enc_ref(input logic [6:0] m);
    logic [14:0] w;
    w = {m, 8'h00};
    for (int d = 14; d >= 8; d--) if (w[d]) w = w ^ (15'h1D1 << (d - 8));
    return {w[7:0], m};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int          m_st = 0;       // 0 idle, 1 encoding, 2 faulted
  int          m_tries = 0;
  logic [6:0]  m_info = '0;
  logic        e_valid = 1'b0;
  logic [14:0] e_code = '0;
  int          e_retry = 0;
  logic        e_fault = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = 0; m_tries = 0; m_info = '0;
      e_valid = 1'b0; e_code = '0; e_retry = 0; e_fault = 1'b0;
    end else begin
      e_valid = 1'b0;
      if (m_st == 0) begin
        if (in_valid) begin m_info = in_info; m_tries = 0; m_st = 1; end
      end else if (m_st == 1) begin
        if (inj_flip == 8'h00) begin
          e_valid = 1'b1; e_code = enc_ref(m_info); e_retry = m_tries; m_st = 0;
        end else if (m_tries == MAX_RETRY) begin
          e_fault = 1'b1; m_st = 2;
        end else begin
          m_tries++;
        end
      end
    end
  end

  always @(negedge clk) begin
    chk(in_ready === (m_st == 0), "R1 in_ready", 32'(in_ready), 32'(m_st == 0));
    chk(out_valid === e_valid, "R5 out_valid", 32'(out_valid), 32'(e_valid));
    chk(out_code[6:0] === e_code[6:0], "R2 info bits", 32'(out_code[6:0]), 32'(e_code[6:0]));
    chk(out_code[14:7] === e_code[14:7], "R3 parity bits", 32'(out_code[14:7]),
        32'(e_code[14:7]));
    chk(out_retry === e_retry[1:0], "R6 retry count", 32'(out_retry), 32'(e_retry));
    chk(enc_fault === e_fault, "R7 fault flag", 32'(enc_fault), 32'(e_fault));
  end

  task automatic send(input logic [6:0] info, input int nbad, input logic [7:0] pat);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_info = info;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < nbad; i++) begin
      inj_flip = pat;
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 flipped attempt withheld", 32'(out_valid), 32'd0);
    end
    inj_flip = '0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 release after 1+r cycles", 32'(out_valid), 32'd1);
    chk(out_retry == 2'(nbad), "R6 retries at release", 32'(out_retry), 32'(nbad));
    chk(out_code == enc_ref(info), "R3 released codeword", 32'(out_code),
        32'(enc_ref(info)));
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 single-cycle strobe", 32'(out_valid), 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R5 actual=hung expected=completed cycle=%0d", cyc);
    finish_run();
  end

  initial begin
    // R8: reset with a busy flip pattern present
    rst = 1'b1; inj_flip = 8'hA5;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R8 reset ready", 32'(in_ready), 32'd1);
    chk(enc_fault == 1'b0, "R8 reset fault", 32'(enc_fault), 32'd0);
    chk(out_retry == 2'd0, "R8 reset retry", 32'(out_retry), 32'd0);
    chk(out_code == 15'd0, "R8 reset code", 32'(out_code), 32'd0);
    rst = 1'b0; inj_flip = '0;
    @(negedge clk);

    // R9: flips while idle change nothing
    inj_flip = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 idle flip valid", 32'(out_valid), 32'd0);
      chk(out_code == 15'd0, "R9 idle flip code", 32'(out_code), 32'd0);
    end
    inj_flip = '0;

    // R3 fixed vector
    send(7'h01, 0, 8'h00);
    chk(out_code == 15'h6881, "R3 known vector 7'h01", 32'(out_code), 32'h6881);

    // R2 R3: every information word
    for (int v = 0; v < 128; v++) send(7'(v), 0, 8'h00);

    // R4 single-cycle toggle of one parity bit, then longer flips
    send(7'h55, 1, 8'h01);
    send(7'h2A, 2, 8'h80);
    send(7'h7F, 3, 8'h10);   // last permitted attempt passes

    // R1: stream with in_valid held high and occasional flips
    for (int i = 0; i < 300; i++) begin
      in_valid = 1'b1;
      in_info  = 7'($urandom);
      inj_flip = (($urandom % 6) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      @(negedge clk);
    end
    in_valid = 1'b0; inj_flip = '0;
    repeat (6) @(negedge clk);
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);

    // R7: four failing attempts
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_info = 7'h33;
    @(negedge clk);
    in_valid = 1'b0; inj_flip = 8'h04;
    repeat (4) @(negedge clk);
    chk(enc_fault == 1'b1, "R7 fault after 4th failure", 32'(enc_fault), 32'd1);
    chk(in_ready == 1'b0, "R7 ready low in fault", 32'(in_ready), 32'd0);
    inj_flip = '0; in_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(enc_fault == 1'b1, "R7 fault sticky", 32'(enc_fault), 32'd1);
      chk(out_valid == 1'b0, "R7 no release in fault", 32'(out_valid), 32'd0);
    end
    in_valid = 1'b0;

    // R8: reset clears the fault, block works again
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk(enc_fault == 1'b0, "R8 reset clears fault", 32'(enc_fault), 32'd0);
    chk(in_ready == 1'b1, "R8 ready after fault reset", 32'(in_ready), 32'd1);
    send(7'h33, 0, 8'h00);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule